// File: doc/BRIEF.md
# Oscillator Coarse Band Calibration Controller

This block picks one of the 64 coarse tuning curves of a switched-capacitor oscillator before the synthesizer loop closes. The oscillator output, already divided by four, clocks a small edge counter. Over a fixed window of reference cycles that count is compared against a target. The target is the programmed feedback division ratio scaled by the window length over four. A successive-approximation search walks the 6-bit capacitor code from its most significant bit down, one measurement per bit.

A search starts on its own whenever the division-ratio input takes a new value. It can also be started with a one-cycle start pulse. A new value or a start pulse that arrives during a search throws that search away and begins again from the first bit. While a search runs, the block asks the feedback divider to hold its first stages at divide-by-two. It drops that request in the same cycle that it flags completion. The window boundary crosses into the oscillator clock domain through a synchronizer. The count is read back only after a settle gap, once the counter has stopped moving.

Top module: `vco_band_search`

## Requirements
- R1: While reset is held and in the first cycle after it, band_code is 6'b100000 and busy, done and force_div2 are all 0.
- R2: At the first rising edge of clk where ratio differs from its value at the previous edge, busy and force_div2 go to 1.
- R3: A start pulse sampled high at a rising edge launches a search even when ratio is unchanged, with the same effect as R2.
- R4: In the cycle after a search is launched, band_code is 6'b100000. Only the most significant bit is under test.
- R5: Bits are decided from bit 5 down to bit 0. The bit under test stays 1 only when the measured count of osc_clk rising edges over WINDOW reference cycles is strictly greater than ratio*WINDOW/4. Otherwise it is cleared, and the next lower bit is set for the next trial. A larger code means a lower oscillator frequency.
- R6: A search ends with done high for exactly one clk cycle. In that same cycle busy and force_div2 fall to 0 and band_code holds the final result. With default parameters this happens between 200 and 240 reference cycles after launch.
- R7: A new ratio value or a start pulse during a search aborts it without a done pulse. The search restarts from R4, and its result and timing follow the new request.
- R8: With no start pulse and no change in ratio, an idle block keeps busy low and band_code unchanged.
- R9: If the target is below the count of every band, the result is 6'b111111. If it is above the count of every band, the result is 6'b000000.
- R10: force_div2 equals busy in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all control state runs on it |
| rst | input | 1 | Synchronous active-high reset |
| osc_clk | input | 1 | Oscillator output after the divide-by-four stage |
| ratio | input | RATIO_W (8) | Feedback division ratio; any change launches a search |
| start | input | 1 | One-cycle request to search again with the current ratio |
| band_code | output | CODE_W (6) | Capacitor bank code: trial value during a search, final value afterwards |
| busy | output | 1 | High while a search is in progress |
| done | output | 1 | One-cycle pulse when a search completes |
| force_div2 | output | 1 | Holds the first feedback-divider stages at divide-by-two |

## Verification
A wrong bit decision or a reversed comparison shows at the ports as a final band_code that differs from the one predicted by the oscillator model. That difference is visible in the done cycle, about 220 reference cycles after launch. A counter that is not cleared between windows, or a count sampled too early, carries one trial's result into the next and bends the final code. A broken restart path shows up differently: either as a done pulse inside the abort window or as a result that belongs to the older ratio. A trigger detector that fires spuriously raises busy within one cycle of an idle stretch.

// File: rtl/band_cal_pkg.sv
`timescale 1ns/1ps
package band_cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PAUSE   = 2'd1,
    ST_MEASURE = 2'd2,
    ST_HOLD    = 2'd3
  } cal_state_e;

endpackage

// File: rtl/band_cal_sync.sv
`timescale 1ns/1ps
module band_cal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/band_cal_edge_counter.sv
`timescale 1ns/1ps
module band_cal_edge_counter #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             osc_clk,
  input  logic             osc_rst,
  input  logic             gate,
  output logic [CNT_W-1:0] count
);

  logic gate_s;
  logic gate_d;

  band_cal_sync #(.STAGES(SYNC_STAGES)) i_gate_sync (
    .clk (osc_clk),
    .d   (gate),
    .q   (gate_s)
  );

  // The opening edge of a window restarts the count at one, so a window
  // spans the same number of oscillator edges it is open for.
  always_ff @(posedge osc_clk) begin
    if (osc_rst) begin
      gate_d <= 1'b0;
      count  <= '0;
    end else begin
      gate_d <= gate_s;
      if (gate_s && !gate_d) begin
        count <= CNT_W'(1);
      end else if (gate_s && (count != '1)) begin
        count <= count + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/band_cal_search.sv
`timescale 1ns/1ps
module band_cal_search
  import band_cal_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int RATIO_W = 8,
  parameter int CNT_W   = 12,
  parameter int WINDOW  = 32,
  parameter int SETTLE  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               start,
  input  logic [CNT_W-1:0]   meas_count,
  output logic               gate,
  output logic [CODE_W-1:0]  band_code,
  output logic               busy,
  output logic               done,
  output logic               force_div2
);

  localparam int SHIFT  = $clog2(WINDOW) - 2;
  localparam int SPAN   = (WINDOW > SETTLE) ? WINDOW : SETTLE;
  localparam int TMR_W  = $clog2(SPAN) + 1;
  localparam int IDX_W  = $clog2(CODE_W);
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [TMR_W-1:0]  WIN_LAST = TMR_W'(WINDOW - 1);
  localparam logic [TMR_W-1:0]  SET_LAST = TMR_W'(SETTLE - 1);

  cal_state_e         state;
  cal_state_e         state_n;
  logic [TMR_W-1:0]   tmr;
  logic [IDX_W-1:0]   bit_idx;
  logic [RATIO_W-1:0] ratio_q;
  logic [CNT_W-1:0]   target_q;
  logic               trig;
  logic               decide;
  logic               bit_keep;

  assign trig     = start || (ratio != ratio_q);
  assign decide   = (state == ST_HOLD) && (tmr == SET_LAST);
  assign bit_keep = meas_count > target_q;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:    state_n = ST_IDLE;
      ST_PAUSE:   if (tmr == SET_LAST) state_n = ST_MEASURE;
      ST_MEASURE: if (tmr == WIN_LAST) state_n = ST_HOLD;
      ST_HOLD:    if (tmr == SET_LAST) state_n = (bit_idx == '0) ? ST_IDLE : ST_MEASURE;
    endcase
    if (trig) state_n = ST_PAUSE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tmr        <= '0;
      bit_idx    <= IDX_W'(CODE_W - 1);
      ratio_q    <= ratio;
      target_q   <= '0;
      gate       <= 1'b0;
      band_code  <= CODE_MID;
      busy       <= 1'b0;
      done       <= 1'b0;
      force_div2 <= 1'b0;
    end else begin
      ratio_q <= ratio;
      state   <= state_n;
      gate    <= (state_n == ST_MEASURE);
      done    <= 1'b0;
      if (trig || (state_n != state) || (state == ST_IDLE)) begin
        tmr <= '0;
      end else begin
        tmr <= tmr + TMR_W'(1);
      end
      if (trig) begin
        band_code  <= CODE_MID;
        bit_idx    <= IDX_W'(CODE_W - 1);
        target_q   <= CNT_W'(ratio) << SHIFT;
        busy       <= 1'b1;
        force_div2 <= 1'b1;
      end else if (decide) begin
        band_code[bit_idx] <= bit_keep;
        if (bit_idx == '0) begin
          busy       <= 1'b0;
          force_div2 <= 1'b0;
          done       <= 1'b1;
        end else begin
          bit_idx                       <= bit_idx - IDX_W'(1);
          band_code[bit_idx - IDX_W'(1)] <= 1'b1;
        end
      end
    end
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  force_busy_chk: assert property (@(posedge clk) disable iff (rst)
    force_div2 == busy);

  // R2
  launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> busy);

  // R4
  launch_code_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> (band_code == CODE_MID));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !trig) |=> $stable(band_code));

  // R5
  gate_busy_chk: assert property (@(posedge clk) disable iff (rst)
    gate |-> busy);

endmodule

// File: rtl/vco_band_search.sv
`timescale 1ns/1ps
module vco_band_search #(
  parameter int CODE_W      = 6,
  parameter int RATIO_W     = 8,
  parameter int CNT_W       = 12,
  parameter int WINDOW      = 32,
  parameter int SETTLE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               osc_clk,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               start,
  output logic [CODE_W-1:0]  band_code,
  output logic               busy,
  output logic               done,
  output logic               force_div2
);

  logic             gate;
  logic             osc_rst;
  logic [CNT_W-1:0] meas_count;

  band_cal_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk (osc_clk),
    .d   (rst),
    .q   (osc_rst)
  );

  band_cal_edge_counter #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_counter (
    .osc_clk (osc_clk),
    .osc_rst (osc_rst),
    .gate    (gate),
    .count   (meas_count)
  );

  band_cal_search #(
    .CODE_W  (CODE_W),
    .RATIO_W (RATIO_W),
    .CNT_W   (CNT_W),
    .WINDOW  (WINDOW),
    .SETTLE  (SETTLE)
  ) i_search (
    .clk        (clk),
    .rst        (rst),
    .ratio      (ratio),
    .start      (start),
    .meas_count (meas_count),
    .gate       (gate),
    .band_code  (band_code),
    .busy       (busy),
    .done       (done),
    .force_div2 (force_div2)
  );

endmodule

// File: tb/test_vco_band_search.sv
`timescale 1ns/1ps
module test_vco_band_search;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_clk = 1'b0;
  logic       start = 1'b0;
  logic [7:0] ratio = 8'd64;
  logic [5:0] band_code;
  logic       busy;
  logic       done;
  logic       force_div2;

  int checks = 0;
  int fails  = 0;

  vco_band_search i_vco_band_search (
    .clk        (clk),
    .rst        (rst),
    .osc_clk    (osc_clk),
    .ratio      (ratio),
    .start      (start),
    .band_code  (band_code),
    .busy       (busy),
    .done       (done),
    .force_div2 (force_div2)
  );

  always #2.5 clk = ~clk;

  // Oscillator model: band c has period (160 + 16c) ps, so a 160 ns
  // window holds 10000/(10+c) edges; larger codes run slower.
  initial begin
    forever begin
      #((80.0 + 8.0 * real'(band_code)) / 1000.0);
      osc_clk = ~osc_clk;
    end
  end

  function automatic real band_count(int c);
    return 10000.0 / (10.0 + real'(c));
  endfunction

  function automatic int exp_code(int n);
    int code = 0;
    for (int b = 5; b >= 0; b--) begin
      int trial = code | (1 << b);
      if (band_count(trial) > real'(8 * n)) code = trial;
    end
    return code;
  endfunction

  function automatic bit margin_ok(int n);
    for (int c = 0; c < 64; c++) begin
      real d = band_count(c) - real'(8 * n);
      if (d < 2.5 && d > -2.5) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Launches a search (ratio write or start pulse) and follows it to done.
  task automatic run_cal(input bit use_start, input logic [7:0] n, input string tag);
    int k = 0;
    int mism = 0;
    int expv = exp_code(int'(n));
    if (use_start) start = 1'b1;
    else ratio = n;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, use_start ? "R3 busy after start" : "R2 busy after write", busy, 1);
    check(force_div2 == 1'b1, "R10 force after launch", force_div2, 1);
    check(band_code == 6'd32, "R4 first trial code", band_code, 32);
    while (!done && k < 300) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (force_div2 != busy) mism++;
    end
    check(mism == 0, "R10 force equals busy", mism, 0);
    check(done == 1'b1, "R6 done seen", done, 1);
    check(k >= 200 && k <= 240, "R6 search length", k, 220);
    check(band_code == 6'(expv), tag, band_code, expv);
    check(!busy && !force_div2, "R6 busy/force released", {busy, force_div2}, 0);
    cycles(1);
    check(done == 1'b0, "R6 done one cycle", done, 0);
  endtask

  initial begin
    #(60000 * 5);
    checks++;
    fails++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] n;
    int seen;
    logic [5:0] held;
    void'($urandom(32'd2024));
    cycles(3);
    check(band_code == 6'd32 && !busy && !done && !force_div2, "R1 in reset",
          {band_code, busy, done, force_div2}, 32 << 3);
    rst = 1'b0;
    cycles(1);
    check(band_code == 6'd32, "R1 code after reset", band_code, 32);
    check(!busy && !done && !force_div2, "R1 flags after reset", {busy, done, force_div2}, 0);
    cycles(10);
    check(busy == 1'b0, "R8 no launch without change", busy, 0);

    // Corner targets
    run_cal(1'b0, 8'd10, "R9 target below all bands");
    run_cal(1'b0, 8'd126, "R9 target above all bands");

    // Random ratios with a clear margin to every band count
    for (int r = 0; r < 8; r++) begin
      do n = 8'(18 + $urandom_range(0, 107));
      while (!margin_ok(int'(n)) || n == ratio);
      run_cal(1'b0, n, "R5 search result");
    end

    // Relaunch with an unchanged ratio
    run_cal(1'b1, ratio, "R3 start relaunch result");

    // Abort by a new ratio mid-search
    do n = 8'(18 + $urandom_range(0, 107));
    while (!margin_ok(int'(n)) || n == ratio);
    ratio = n;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      cycles(1);
      if (done) seen++;
    end
    check(seen == 0, "R7 no done before abort", seen, 0);
    do n = 8'(18 + $urandom_range(0, 107));
    while (!margin_ok(int'(n)) || n == ratio);
    run_cal(1'b0, n, "R7 result after ratio abort");

    // Abort by a start pulse mid-search
    start = 1'b1;
    cycles(1);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      cycles(1);
      if (done) seen++;
    end
    check(seen == 0, "R7 no done before start abort", seen, 0);
    run_cal(1'b1, ratio, "R7 result after start abort");

    // Idle stretch
    held = band_code;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      cycles(1);
      if (busy || band_code != held) seen++;
    end
    check(seen == 0, "R8 idle hold", seen, 0);

    summary();
    $finish;
  end

endmodule